// File: doc/BRIEF.md
# Processor Control Register Bank

This block holds the processor's control registers: a bank of 32-bit words, each picked by a 5-bit index. Software moves values between the general register file and this bank with two move operations. The move-to-bank operation is issued as a plain write. The move-from-bank operation is issued as a plain read. A 32-bit constant is built in two steps. The first write places a whole word. A following high-half write then replaces bits 31:16 and keeps bits 15:0.

A write commits one stage after it is issued. Consumers that use the stack pointer implicitly see a move written to it, or an add/subtract adjustment of it, in the very next cycle on `sp_view`. An explicit read-back of the same register, issued in the cycle right after the write, falls in an exposed slot with no interlock. Its result is unspecified, and the design returns the older value. The bank also contains a read-only identification word and a free-running 64-bit time-stamp counter, which is read as two 32-bit halves.

The block has no streaming data interface. Every pin is a plain control or data signal, sampled on every rising clock edge, and nothing is held back by back-pressure.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, every writable register is zero, `rd_valid` is low, `sp_view` is zero, and index 19 reads the parameter `CPUID_VAL`.
- R2: A write with `mv_wr_hi`=0 stores all 32 bits of `mv_wr_data` at `mv_wr_idx`. Index map: 0 status, 1..6 interrupt and return words, 7 stack pointer, 8..18 data, loop and shadow words, 19 identification, 20 decode PC, 21 counter high, 22 counter low.
- R3: A write with `mv_wr_hi`=1 sets bits 31:16 of the target to `mv_wr_data[15:0]` and leaves bits 15:0 unchanged. This holds even when the high-half write directly follows the full write to the same index.
- R4: A read issued with `mv_rd_en` drives `rd_data` and raises `rd_valid` in the next cycle. `rd_valid` is low in the cycle after a cycle without a read.
- R5: A read of an index issued two or more cycles after a write to that index returns the written value. A read issued in the cycle immediately after the write is unspecified.
- R6: A move write to index 7 appears on `sp_view` in the cycle after issue. `sp_view` is unchanged when neither a stack-pointer write nor an adjustment is issued.
- R7: `sp_adj_en` adds `sp_adj_amt` to the current `sp_view`, or subtracts it when `sp_adj_sub`=1. The result appears on `sp_view` the next cycle, and back-to-back adjustments accumulate.
- R8: When a move write to index 7 and an adjustment are issued in the same cycle, the move value wins and the adjustment is discarded.
- R9: Index 19 is read-only. Writes to it have no effect.
- R10: Indices 23 to 31 always read zero and ignore writes.
- R11: The 64-bit counter starts at zero after reset and increments by one every clock. Index 22 gives bits 31:0 and index 21 gives bits 63:32. Writes to both indices are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_wr_en | input | 1 | Issue a move into the bank |
| mv_wr_hi | input | 1 | 1: high-half write, 0: full-word write |
| mv_wr_idx | input | 5 | Target register index |
| mv_wr_data | input | 32 | Write value (low 16 bits used for a high-half write) |
| mv_rd_en | input | 1 | Issue a move out of the bank |
| mv_rd_idx | input | 5 | Source register index |
| sp_adj_en | input | 1 | Issue a stack pointer adjustment |
| sp_adj_sub | input | 1 | 1: subtract, 0: add |
| sp_adj_amt | input | 32 | Adjustment amount |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_data | output | 32 | Read result, one cycle after issue |
| sp_view | output | 32 | Stack pointer as seen by the next instruction |

## Verification
A table of write/read-back vectors covers several kinds of write on their own. Full-word writes to different indices show that index decoding is correct. A full write followed at once by a high-half write shows that the merge uses the still-pending low half rather than the committed value. Writes to the identification word and to unused indices show that read-only and absent slots are kept apart from storage. Directed sequences then exercise the stack pointer in three cases: a move, chained adjustments, and a same-cycle collision, which separates bypass from commit and shows the priority. They also test reads placed just inside and just past the exposed slot, and counter reads on consecutive cycles.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int CR_W      = 32;
  localparam int CR_HALF   = CR_W / 2;
  localparam int CR_IDX_W  = 5;
  localparam int TSC_W     = 2 * CR_W;
  localparam int IDX_SP    = 7;
  localparam int IDX_CPUID = 19;
  localparam int IDX_TSCH  = 21;
  localparam int IDX_TSCL  = 22;
  localparam int NUM_STORE = 21;

  typedef struct packed {
    logic                vld;
    logic [CR_IDX_W-1:0] idx;
    logic [CR_W-1:0]     val;
  } mv_pend_t;
endpackage

// File: rtl/ctl_tsc.sv
module ctl_tsc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/ctl_wr_stage.sv
module ctl_wr_stage
  import ctl_regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_hi,
  input  logic [CR_IDX_W-1:0] wr_idx,
  input  logic [CR_W-1:0]     wr_data,
  input  logic [CR_W-1:0]     cur_tgt,
  input  logic                adj_en,
  input  logic                adj_sub,
  input  logic [CR_W-1:0]     adj_amt,
  input  logic [CR_W-1:0]     cur_sp,
  output mv_pend_t            mv_pend,
  output logic                sp_pend_vld,
  output logic [CR_W-1:0]     sp_pend_val
);
  mv_pend_t        mv_nxt;
  logic            sp_nxt_vld;
  logic [CR_W-1:0] sp_nxt_val;
  logic            mv_hits_sp;

  assign mv_hits_sp = wr_en && (wr_idx == CR_IDX_W'(IDX_SP));

  always_comb begin
    mv_nxt.vld = wr_en;
    mv_nxt.idx = wr_idx;
    mv_nxt.val = wr_hi ? {wr_data[CR_HALF-1:0], cur_tgt[CR_HALF-1:0]} : wr_data;
    sp_nxt_vld = adj_en && !mv_hits_sp;
    sp_nxt_val = adj_sub ? (cur_sp - adj_amt) : (cur_sp + adj_amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_pend     <= '0;
      sp_pend_vld <= 1'b0;
      sp_pend_val <= '0;
    end else begin
      mv_pend     <= mv_nxt;
      sp_pend_vld <= sp_nxt_vld;
      sp_pend_val <= sp_nxt_val;
    end
  end
endmodule

// File: rtl/ctl_store.sv
module ctl_store
  import ctl_regbank_pkg::*;
#(
  parameter logic [CR_W-1:0] CPUID_VAL = 32'hC0DE_0A32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  mv_pend_t                        mv_pend,
  input  logic                            sp_pend_vld,
  input  logic [CR_W-1:0]                 sp_pend_val,
  output logic [NUM_STORE-1:0][CR_W-1:0]  q
);
  for (genvar i = 0; i < NUM_STORE; i++) begin : g_reg
    if (i == IDX_CPUID) begin : g_ro
      assign q[i] = CPUID_VAL;
    end else begin : g_rw
      logic [CR_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          r <= '0;
        else if (mv_pend.vld && mv_pend.idx == CR_IDX_W'(i))
          r <= mv_pend.val;
        else if ((i == IDX_SP) && sp_pend_vld)
          r <= sp_pend_val;
      end
      assign q[i] = r;
    end
  end
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter logic [CR_W-1:0] CPUID_VAL = 32'hC0DE_0A32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mv_wr_en,
  input  logic                mv_wr_hi,
  input  logic [CR_IDX_W-1:0] mv_wr_idx,
  input  logic [CR_W-1:0]     mv_wr_data,
  input  logic                mv_rd_en,
  input  logic [CR_IDX_W-1:0] mv_rd_idx,
  input  logic                sp_adj_en,
  input  logic                sp_adj_sub,
  input  logic [CR_W-1:0]     sp_adj_amt,
  output logic                rd_valid,
  output logic [CR_W-1:0]     rd_data,
  output logic [CR_W-1:0]     sp_view
);
  mv_pend_t                       mv_pend;
  logic                           sp_pend_vld;
  logic [CR_W-1:0]                sp_pend_val;
  logic [NUM_STORE-1:0][CR_W-1:0] q;
  logic [TSC_W-1:0]               tsc;
  logic [CR_W-1:0]                cur_tgt;
  logic [CR_W-1:0]                rd_mux;

  ctl_tsc #(.W(TSC_W)) u_tsc (.clk(clk), .rst_n(rst_n), .cnt(tsc));

  ctl_wr_stage u_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mv_wr_en), .wr_hi(mv_wr_hi), .wr_idx(mv_wr_idx), .wr_data(mv_wr_data),
    .cur_tgt(cur_tgt),
    .adj_en(sp_adj_en), .adj_sub(sp_adj_sub), .adj_amt(sp_adj_amt),
    .cur_sp(sp_view),
    .mv_pend(mv_pend), .sp_pend_vld(sp_pend_vld), .sp_pend_val(sp_pend_val)
  );

  ctl_store #(.CPUID_VAL(CPUID_VAL)) u_store (
    .clk(clk), .rst_n(rst_n),
    .mv_pend(mv_pend), .sp_pend_vld(sp_pend_vld), .sp_pend_val(sp_pend_val),
    .q(q)
  );

  // Implicit consumers see pending updates (bypass)
  always_comb begin
    if (mv_pend.vld && mv_pend.idx == CR_IDX_W'(IDX_SP)) sp_view = mv_pend.val;
    else if (sp_pend_vld)                                  sp_view = sp_pend_val;
    else                                                   sp_view = q[IDX_SP];
  end

  // Merge base for a high-half write: newest value of the target
  always_comb begin
    cur_tgt = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (mv_wr_idx == CR_IDX_W'(i)) cur_tgt = q[i];
    if (mv_wr_idx == CR_IDX_W'(IDX_SP))
      cur_tgt = sp_view;
    else if (mv_pend.vld && mv_pend.idx == mv_wr_idx)
      cur_tgt = mv_pend.val;
  end

  // Explicit reads see only committed state (exposed slot)
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_STORE; i++)
      if (mv_rd_idx == CR_IDX_W'(i)) rd_mux = q[i];
    if (mv_rd_idx == CR_IDX_W'(IDX_TSCH)) rd_mux = tsc[TSC_W-1:CR_W];
    if (mv_rd_idx == CR_IDX_W'(IDX_TSCL)) rd_mux = tsc[CR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= mv_rd_en;
      if (mv_rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
#(
  parameter logic [CR_W-1:0] CPUID_VAL = 32'hC0DE_0A32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mv_wr_en,
  input logic                mv_wr_hi,
  input logic [CR_IDX_W-1:0] mv_wr_idx,
  input logic [CR_W-1:0]     mv_wr_data,
  input logic                mv_rd_en,
  input logic [CR_IDX_W-1:0] mv_rd_idx,
  input logic                sp_adj_en,
  input logic                sp_adj_sub,
  input logic [CR_W-1:0]     sp_adj_amt,
  input logic                rd_valid,
  input logic [CR_W-1:0]     rd_data,
  input logic [CR_W-1:0]     sp_view
);
  logic mv_sp_full, mv_sp_any;
  assign mv_sp_any  = mv_wr_en && (mv_wr_idx == CR_IDX_W'(IDX_SP));
  assign mv_sp_full = mv_sp_any && !mv_wr_hi;

  assert_rd_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mv_rd_en |=> rd_valid);
  assert_rd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_rd_en |=> !rd_valid);
  assert_sp_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_sp_full && !sp_adj_en) |=> sp_view == $past(mv_wr_data));
  assert_sp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mv_sp_any && !sp_adj_en) |=> $stable(sp_view));
  assert_sp_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_adj_en && !sp_adj_sub && !mv_sp_any) |=> sp_view == $past(sp_view + sp_adj_amt));
  assert_sp_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_adj_en && sp_adj_sub && !mv_sp_any) |=> sp_view == $past(sp_view - sp_adj_amt));
  assert_sp_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_sp_full && sp_adj_en) |=> sp_view == $past(mv_wr_data));
  assert_cpuid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_rd_en && mv_rd_idx == CR_IDX_W'(IDX_CPUID)) |=> rd_data == CPUID_VAL);
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_rd_en && mv_rd_idx > CR_IDX_W'(IDX_TSCL)) |=> rd_data == '0);
endmodule

bind ctl_regbank ctl_regbank_chk #(.CPUID_VAL(CPUID_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mv_wr_en(mv_wr_en), .mv_wr_hi(mv_wr_hi), .mv_wr_idx(mv_wr_idx), .mv_wr_data(mv_wr_data),
  .mv_rd_en(mv_rd_en), .mv_rd_idx(mv_rd_idx),
  .sp_adj_en(sp_adj_en), .sp_adj_sub(sp_adj_sub), .sp_adj_amt(sp_adj_amt),
  .rd_valid(rd_valid), .rd_data(rd_data), .sp_view(sp_view)
);

// File: tb/ctl_regbank_bench.sv
module ctl_regbank_bench;
  localparam logic [31:0] CPUID = 32'hC0DE_0A32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mv_wr_en = 1'b0, mv_wr_hi = 1'b0, mv_rd_en = 1'b0;
  logic [4:0]  mv_wr_idx = '0, mv_rd_idx = '0;
  logic [31:0] mv_wr_data = '0;
  logic        sp_adj_en = 1'b0, sp_adj_sub = 1'b0;
  logic [31:0] sp_adj_amt = '0;
  logic        rd_valid;
  logic [31:0] rd_data, sp_view;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] t_a, t_b;

  always #10 clk = ~clk;

  ctl_regbank #(.CPUID_VAL(CPUID)) u_ctl_regbank (
    .clk(clk), .rst_n(rst_n),
    .mv_wr_en(mv_wr_en), .mv_wr_hi(mv_wr_hi), .mv_wr_idx(mv_wr_idx), .mv_wr_data(mv_wr_data),
    .mv_rd_en(mv_rd_en), .mv_rd_idx(mv_rd_idx),
    .sp_adj_en(sp_adj_en), .sp_adj_sub(sp_adj_sub), .sp_adj_amt(sp_adj_amt),
    .rd_valid(rd_valid), .rd_data(rd_data), .sp_view(sp_view)
  );

  typedef struct packed {
    logic [4:0]  idx;
    logic [31:0] lo;
    logic        use_hi;
    logic [15:0] hi;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t [0:7] VECS = '{
    '{5'd0,  32'h1234_5678, 1'b0, 16'h0000, 32'h1234_5678},  // R2
    '{5'd12, 32'h0000_07D0, 1'b0, 16'h0000, 32'h0000_07D0},  // R2
    '{5'd5,  32'hFFFF_0001, 1'b1, 16'hABCD, 32'hABCD_0001},  // R3
    '{5'd20, 32'h0000_0000, 1'b1, 16'h8000, 32'h8000_0000},  // R3
    '{5'd19, 32'hFFFF_FFFF, 1'b1, 16'h1111, CPUID},          // R9
    '{5'd23, 32'hDEAD_BEEF, 1'b0, 16'h0000, 32'h0},          // R10
    '{5'd31, 32'h0000_5555, 1'b1, 16'h7777, 32'h0},          // R10
    '{5'd16, 32'h0000_0003, 1'b1, 16'h0001, 32'h0001_0003}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read an index; rd_data is sampled at the negedge after the issuing edge
  task automatic read_idx(input logic [4:0] idx, output logic [31:0] val);
    @(negedge clk); mv_rd_en = 1'b1; mv_rd_idx = idx;
    @(negedge clk); mv_rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic write_idx(input logic [4:0] idx, input logic hi, input logic [31:0] d);
    @(negedge clk); mv_wr_en = 1'b1; mv_wr_hi = hi; mv_wr_idx = idx; mv_wr_data = d;
    @(negedge clk); mv_wr_en = 1'b0; mv_wr_hi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    check("R1 sp_view", sp_view, 32'h0);
    read_idx(5'd0, v);  check("R1 status zero", v, 32'h0);
    check("R4 rd_valid after read", {31'b0, rd_valid}, 32'h1);
    read_idx(5'd19, v); check("R1 id word", v, CPUID);
    @(negedge clk);
    check("R4 rd_valid idle", {31'b0, rd_valid}, 32'h0);

    // Vector table
    foreach (VECS[i]) begin
      @(negedge clk); mv_wr_en = 1'b1; mv_wr_hi = 1'b0; mv_wr_idx = VECS[i].idx; mv_wr_data = VECS[i].lo;
      @(negedge clk);
      if (VECS[i].use_hi) begin mv_wr_hi = 1'b1; mv_wr_data = {16'h0, VECS[i].hi}; end
      else mv_wr_en = 1'b0;
      @(negedge clk); mv_wr_en = 1'b0; mv_wr_hi = 1'b0;
      read_idx(VECS[i].idx, v);
      checks++;
      if (v !== VECS[i].exp) begin
        failures++;
        $display("FAIL vector %0d (R2/R3/R9/R10) actual=%h expected=%h", i, v, VECS[i].exp);
      end
    end
    read_idx(5'd0, v); check("R2 status retained", v, 32'h1234_5678);

    // Exposed slot: read right after write is ignored, next read returns new value
    @(negedge clk); mv_wr_en = 1'b1; mv_wr_hi = 1'b0; mv_wr_idx = 5'd9; mv_wr_data = 32'h0000_AAAA;
    @(negedge clk); mv_wr_en = 1'b0; mv_rd_en = 1'b1; mv_rd_idx = 5'd9;
    @(negedge clk);
    @(negedge clk); mv_rd_en = 1'b0;
    check("R5 read after slot", rd_data, 32'h0000_AAAA);

    // Stack pointer bypass
    @(negedge clk); mv_wr_en = 1'b1; mv_wr_idx = 5'd7; mv_wr_data = 32'd5000;
    @(negedge clk); mv_wr_en = 1'b0;
    check("R6 sp bypass", sp_view, 32'd5000);
    @(negedge clk);
    check("R6 sp hold", sp_view, 32'd5000);

    // Adjustments
    @(negedge clk); sp_adj_en = 1'b1; sp_adj_sub = 1'b0; sp_adj_amt = 32'd16;
    @(negedge clk); sp_adj_sub = 1'b1; sp_adj_amt = 32'd4;
    check("R7 sp add", sp_view, 32'd5016);
    @(negedge clk); sp_adj_en = 1'b0;
    check("R7 sp sub chained", sp_view, 32'd5012);
    @(negedge clk);
    read_idx(5'd7, v); check("R7 sp committed", v, 32'd5012);

    // Collision
    @(negedge clk); mv_wr_en = 1'b1; mv_wr_idx = 5'd7; mv_wr_data = 32'h100;
    sp_adj_en = 1'b1; sp_adj_sub = 1'b0; sp_adj_amt = 32'd8;
    @(negedge clk); mv_wr_en = 1'b0; sp_adj_en = 1'b0;
    check("R8 move wins", sp_view, 32'h100);
    @(negedge clk);
    check("R8 move wins committed", sp_view, 32'h100);

    // Time-stamp counter
    @(negedge clk); mv_rd_en = 1'b1; mv_rd_idx = 5'd22;
    @(negedge clk); t_a = rd_data;
    @(negedge clk); mv_rd_en = 1'b0; t_b = rd_data;
    check("R11 low increments", t_b, t_a + 32'd1);
    read_idx(5'd21, v); check("R11 high zero", v, 32'h0);
    write_idx(5'd22, 1'b0, 32'hDEAD_0000);
    @(negedge clk);
    read_idx(5'd22, v);
    check("R11 write ignored", {31'b0, (v > t_b) && (v < 32'd2000)}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule